// File: doc/BRIEF.md
# Sampled-Clock Phase Alignment Controller

This block centres the sampling phase of a deserialized link clock inside its valid eye. The link clock is captured as a 7-bit sampled word. A phase is good only when that word shows the expected clock shape. The controller drives a dynamic phase shifter one step at a time through a request/done handshake. It first leaves any good region it started in. It then searches forward for a fresh good window, measures the window's width in steps, and walks back to the window's centre.

A single `start` pulse from idle begins an alignment run. The run ends with a one-cycle `done` pulse. `success` is high in that cycle when a window was found and centred. The measured width stays on `win_width` until the next start. The controller is meant to be restarted by whatever supervises the link, for example after a PLL relock.

States: `ST_IDLE` (waiting), `ST_LEAVE_CHK` / `ST_LEAVE_STEP` (step forward while good), `ST_EXTRA_STEP` (one forward step past the edge), `ST_SEEK_CHK` / `ST_SEEK_STEP` (counted forward search), `ST_OPEN_STEP` (first step into the window), `ST_WIN_CHK` / `ST_WIN_STEP` (width measurement), `ST_BACK_STEP` / `ST_BACK_GAP` (backward steps with an idle cycle between requests), `ST_FINISH` (result pulse).

Transitions:
- IDLE→LEAVE_CHK on start.
- LEAVE_CHK→LEAVE_STEP on a good verdict, and →EXTRA_STEP on a bad one.
- LEAVE_STEP→LEAVE_CHK when the step completes.
- EXTRA_STEP→SEEK_CHK when the step completes.
- SEEK_CHK→OPEN_STEP on a good verdict, and →SEEK_STEP on a bad one.
- SEEK_STEP→SEEK_CHK when the step completes, or →FINISH (fail) when the limit is exceeded.
- OPEN_STEP→WIN_CHK when the step completes.
- WIN_CHK→WIN_STEP on a good verdict. On a bad verdict it goes to BACK_STEP, or straight to FINISH (ok) when half the width is zero.
- WIN_STEP→WIN_CHK when the step completes.
- BACK_STEP→BACK_GAP when the step completes with steps remaining, or →FINISH (ok) after the last one.
- BACK_GAP→BACK_STEP unconditionally.
- FINISH→IDLE unconditionally.

Top module: `phase_align_ctrl`

## Requirements
- R1: A sample counts as a match only when `clk_sample` equals 7'b1100011 exactly; any other value, including a single flipped bit, is a mismatch.
- R2: A phase is judged good only after FILTER_LEN consecutive matching samples; one mismatch judges it bad at once, and the sample count restarts from zero after every phase step.
- R3: Each step raises `shift_req` with `shift_dir` (1 = forward, 0 = backward). The request and the direction hold until `shift_done` is seen. The request then drops, and it stays low for at least one cycle before the next request.
- R4: After start, the controller steps forward while the current phase is good, then takes exactly one more forward step.
- R5: It then steps forward while the phase is bad, counting steps; when the count exceeds SEEK_LIMIT the run ends with `success` low and `win_width` zero.
- R6: On the first good phase of the search, the width is set to 1. The controller steps forward once, then adds one to the width for each further good phase, with a forward step after each.
- R7: The width counter saturates at 2^WIDTH_W−1 instead of wrapping.
- R8: When the window ends, exactly width/2 (integer division) backward steps are taken and the run ends with `success` high.
- R9: `done` is a one-cycle pulse. `success` is valid only in that cycle. `busy` is high from the cycle after start until the cycle after `done`.
- R10: `start` has no effect while `busy` is high: a run produces exactly one `done` and an unchanged result.
- R11: After reset, `busy`, `done`, `success` and `shift_req` are low and `win_width` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an alignment run (ignored while busy) |
| clk_sample | input | 7 | Sampled link-clock word |
| shift_done | input | 1 | Phase shifter has completed the requested step |
| shift_req | output | 1 | Phase step request, held until shift_done |
| shift_dir | output | 1 | Step direction: 1 forward, 0 backward |
| busy | output | 1 | Alignment run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | Run result, valid with done |
| win_width | output | 4 | Measured good-window width in steps |

## Verification
The bench builds the controller with FILTER_LEN = 8, SEEK_LIMIT = 20 and WIDTH_W = 4, against a 40-position circular phase model with a 3-cycle shifter latency. With these values, one sweep of window widths from 1 to 20 and of many start phases covers several regimes. Some runs start inside the window and some outside. Some searches fail just past the step limit, and some windows are wide enough to saturate the width counter. A flaky phase that drops one sample in five splits windows and confirms that a near-good phase is rejected.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAVE_CHK,
        ST_LEAVE_STEP,
        ST_EXTRA_STEP,
        ST_SEEK_CHK,
        ST_SEEK_STEP,
        ST_OPEN_STEP,
        ST_WIN_CHK,
        ST_WIN_STEP,
        ST_BACK_STEP,
        ST_BACK_GAP,
        ST_FINISH
    } pa_state_e;

    localparam logic DIR_FWD = 1'b1;
    localparam logic DIR_BWD = 1'b0;

endpackage

// File: rtl/pa_match_filter.sv
module pa_match_filter #(
    parameter int          PAT_W  = 7,
    parameter logic [PAT_W-1:0] PAT = 7'b1100011,
    parameter int          LEN    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PAT_W-1:0] sample,
    output logic             good,
    output logic             bad
);
    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0] hits_q;
    logic             hit;

    assign hit  = (sample == PAT);
    assign good = run && hit && (hits_q == LAST);
    assign bad  = run && !hit;

    // Consecutive-match counter; cleared whenever the check is not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !hit) begin
            hits_q <= '0;
        end else if (hits_q != LAST) begin
            hits_q <= hits_q + 1'b1;
        end
    end

endmodule

// File: rtl/pa_shift_port.sv
module pa_shift_port (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_dir,
    input  logic shift_done,
    output logic shift_req,
    output logic shift_dir,
    output logic complete
);
    logic req_q;
    logic dir_q;

    assign shift_req = req_q;
    assign shift_dir = dir_q;
    assign complete  = req_q && shift_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            dir_q <= 1'b0;
        end else if (issue) begin
            req_q <= 1'b1;
            dir_q <= issue_dir;
        end else if (complete) begin
            req_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pa_sat_counter.sv
module pa_sat_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load_one,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign value = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load_one) begin
            cnt_q <= W'(1);
        end else if (inc && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl #(
    parameter int FILTER_LEN = 128,
    parameter int SEEK_LIMIT = 1024,
    parameter int WIDTH_W    = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [6:0]         clk_sample,
    input  logic               shift_done,
    output logic               shift_req,
    output logic               shift_dir,
    output logic               busy,
    output logic               done,
    output logic               success,
    output logic [WIDTH_W-1:0] win_width
);
    import pa_pkg::*;

    localparam int SEEK_W = $clog2(SEEK_LIMIT + 1);
    localparam logic [SEEK_W-1:0] SEEK_MAX = SEEK_W'(SEEK_LIMIT);
    localparam logic [6:0] CLK_SHAPE = 7'b1100011;

    pa_state_e state_q, state_d;

    logic               chk_run;
    logic               chk_good;
    logic               chk_bad;
    logic               issue;
    logic               issue_dir;
    logic               step_ok;
    logic               w_clr;
    logic               w_one;
    logic               w_inc;
    logic               ok_d;
    logic               ok_q;
    logic [SEEK_W-1:0]  seek_q;
    logic [WIDTH_W-1:0] back_q;
    logic [WIDTH_W-1:0] half_w;

    pa_match_filter #(
        .PAT_W (7),
        .PAT   (CLK_SHAPE),
        .LEN   (FILTER_LEN)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (chk_run),
        .sample (clk_sample),
        .good   (chk_good),
        .bad    (chk_bad)
    );

    pa_shift_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_dir  (issue_dir),
        .shift_done (shift_done),
        .shift_req  (shift_req),
        .shift_dir  (shift_dir),
        .complete   (step_ok)
    );

    pa_sat_counter #(
        .W (WIDTH_W)
    ) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (w_clr),
        .load_one (w_one),
        .inc      (w_inc),
        .value    (win_width)
    );

    assign half_w  = win_width >> 1;
    assign chk_run = (state_q == ST_LEAVE_CHK) || (state_q == ST_SEEK_CHK) ||
                     (state_q == ST_WIN_CHK);

    // Next-state and step-issue decisions
    always_comb begin
        state_d   = state_q;
        issue     = 1'b0;
        issue_dir = DIR_FWD;
        w_clr     = 1'b0;
        w_one     = 1'b0;
        w_inc     = 1'b0;
        ok_d      = ok_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LEAVE_CHK;
                    w_clr   = 1'b1;
                end
            end
            ST_LEAVE_CHK: begin
                if (chk_good) begin
                    state_d = ST_LEAVE_STEP;
                    issue   = 1'b1;
                end else if (chk_bad) begin
                    state_d = ST_EXTRA_STEP;
                    issue   = 1'b1;
                end
            end
            ST_LEAVE_STEP: begin
                if (step_ok) state_d = ST_LEAVE_CHK;
            end
            ST_EXTRA_STEP: begin
                if (step_ok) state_d = ST_SEEK_CHK;
            end
            ST_SEEK_CHK: begin
                if (chk_good) begin
                    state_d = ST_OPEN_STEP;
                    issue   = 1'b1;
                    w_one   = 1'b1;
                end else if (chk_bad) begin
                    state_d = ST_SEEK_STEP;
                    issue   = 1'b1;
                end
            end
            ST_SEEK_STEP: begin
                if (step_ok) begin
                    if (seek_q == SEEK_MAX) begin
                        state_d = ST_FINISH;
                        ok_d    = 1'b0;
                        w_clr   = 1'b1;
                    end else begin
                        state_d = ST_SEEK_CHK;
                    end
                end
            end
            ST_OPEN_STEP: begin
                if (step_ok) state_d = ST_WIN_CHK;
            end
            ST_WIN_CHK: begin
                if (chk_good) begin
                    state_d = ST_WIN_STEP;
                    issue   = 1'b1;
                    w_inc   = 1'b1;
                end else if (chk_bad) begin
                    if (half_w == '0) begin
                        state_d = ST_FINISH;
                        ok_d    = 1'b1;
                    end else begin
                        state_d   = ST_BACK_STEP;
                        issue     = 1'b1;
                        issue_dir = DIR_BWD;
                    end
                end
            end
            ST_WIN_STEP: begin
                if (step_ok) state_d = ST_WIN_CHK;
            end
            ST_BACK_STEP: begin
                if (step_ok) begin
                    if (back_q == WIDTH_W'(1)) begin
                        state_d = ST_FINISH;
                        ok_d    = 1'b1;
                    end else begin
                        state_d = ST_BACK_GAP;
                    end
                end
            end
            ST_BACK_GAP: begin
                state_d   = ST_BACK_STEP;
                issue     = 1'b1;
                issue_dir = DIR_BWD;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and step counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            seek_q  <= '0;
            back_q  <= '0;
        end else begin
            state_q <= state_d;
            ok_q    <= ok_d;
            if (state_q == ST_EXTRA_STEP) begin
                seek_q <= '0;
            end else if (state_q == ST_SEEK_STEP && step_ok && seek_q != SEEK_MAX) begin
                seek_q <= seek_q + 1'b1;
            end
            if (state_q == ST_WIN_CHK && chk_bad) begin
                back_q <= half_w;
            end else if (state_q == ST_BACK_STEP && step_ok) begin
                back_q <= back_q - 1'b1;
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        success = (state_q == ST_FINISH) && ok_q;
    end

endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int WIDTH_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               shift_done,
    input logic               shift_req,
    input logic               shift_dir,
    input logic               busy,
    input logic               done,
    input logic               success,
    input logic [WIDTH_W-1:0] win_width
);
    // R3: request holds until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req && !shift_done) |=> shift_req);

    // R3: request drops after acknowledge, leaving a gap
    p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req && shift_done) |=> !shift_req);

    // R3: direction stable while a request is pending
    p_dir_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_req && !shift_done) |=> $stable(shift_dir));

    // R9: done is a single-cycle pulse that ends the run
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: success only accompanies done
    p_success_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> done);

    // R11: no step request outside a run
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !shift_req);

    // R7: width never wraps downward within a run
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !done) |-> (win_width >= $past(win_width)));

    // R10: a start pulse during a run does not end or restart it
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind phase_align_ctrl pa_checker #(.WIDTH_W(WIDTH_W)) u_pa_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .shift_done (shift_done),
    .shift_req  (shift_req),
    .shift_dir  (shift_dir),
    .busy       (busy),
    .done       (done),
    .success    (success),
    .win_width  (win_width)
);

// File: tb/test_phase_align_ctrl.sv
module test_phase_align_ctrl;

    localparam int FLEN  = 8;
    localparam int LIMIT = 20;
    localparam int WW    = 4;
    localparam int WMAX  = (1 << WW) - 1;
    localparam int NPH   = 40;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [6:0]    clk_sample;
    logic          shift_done = 1'b0;
    logic          shift_req;
    logic          shift_dir;
    logic          busy;
    logic          done;
    logic          success;
    logic [WW-1:0] win_width;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // phase model state
    int phase = 0;
    int win_a = 10;
    int win_w = 1;
    bit flaky = 0;
    int flaky_ph = 0;
    int load_val = 0;
    bit load_ph = 0;
    int lat_cnt = 0;
    bit seen = 0;
    bit dir_l = 0;
    int bwd_steps = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    phase_align_ctrl #(
        .FILTER_LEN (FLEN),
        .SEEK_LIMIT (LIMIT),
        .WIDTH_W    (WW)
    ) i_phase_align_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .clk_sample (clk_sample),
        .shift_done (shift_done),
        .shift_req  (shift_req),
        .shift_dir  (shift_dir),
        .busy       (busy),
        .done       (done),
        .success    (success),
        .win_width  (win_width)
    );

    function automatic int md(int p);
        return ((p % NPH) + NPH) % NPH;
    endfunction

    function automatic bit raw_good(int p);
        return md(p - win_a) < win_w;
    endfunction

    function automatic bit ref_good(int p);
        return raw_good(p) && !(flaky && p == flaky_ph);
    endfunction

    // sampled word: exact shape when good, one flipped bit otherwise (R1)
    always_comb begin
        if (raw_good(phase) && !(flaky && phase == flaky_ph && (cyc % 5) == 0))
            clk_sample = 7'b1100011;
        else
            clk_sample = 7'b1100011 ^ (7'b1 << (phase % 7));
    end

    // phase shifter model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (load_ph) begin
            phase <= load_val;
            bwd_steps <= 0;
            done_cnt <= 0;
        end
        if (shift_done) begin
            shift_done <= 1'b0;
        end else if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                shift_done <= 1'b1;
                phase <= dir_l ? md(phase + 1) : md(phase - 1);
                if (!dir_l) bwd_steps <= bwd_steps + 1;
            end
        end else if (shift_req && !seen) begin
            lat_cnt <= LAT;
            dir_l <= shift_dir;
            seen <= 1'b1;
        end
        if (!shift_req) seen <= 1'b0;
    end

    task automatic check(bit cond, string req, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (p=%0d w=%0d)", req, act, exp, load_val, win_w);
        end
    endtask

    // arithmetic reference of the alignment sweep
    task automatic ref_align(input int p0, output bit ok, output int fin, output int wd);
        int p = p0;
        int cnt = 0;
        ok = 0;
        wd = 0;
        while (ref_good(p)) p = md(p + 1);                  // R4
        p = md(p + 1);
        while (!ref_good(p)) begin                            // R5
            p = md(p + 1);
            cnt++;
            if (cnt > LIMIT) begin
                fin = p;
                return;
            end
        end
        wd = 1;                                               // R6
        p = md(p + 1);
        while (ref_good(p)) begin
            p = md(p + 1);
            if (wd < WMAX) wd++;                              // R7
        end
        p = md(p - wd / 2);                                   // R8
        ok = 1;
        fin = p;
    endtask

    task automatic run_case(int p0, int w, bit fl, int fp, bit extra_start);
        bit ok;
        int fin;
        int wd;
        int guard = 0;
        win_w = w;
        flaky = fl;
        flaky_ph = fp;
        load_val = p0;
        @(negedge clk);
        load_ph = 1;
        @(negedge clk);
        load_ph = 0;
        ref_align(p0, ok, fin, wd);
        start = 1;
        @(negedge clk);
        start = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (extra_start && guard == 30) start = 1;        // R10
            else start = 0;
        end
        start = 0;
        check(done == 1'b1, "R9 done", done, 1);
        check(success == ok, "R5/R8 success", success, ok);
        check(int'(win_width) == wd, "R6/R7 width", win_width, wd);
        check(phase == fin, "R4/R8 final phase", phase, fin);
        if (ok) check(bwd_steps == wd / 2, "R8 backward steps", bwd_steps, wd / 2);
        @(negedge clk);
        check(!done && !busy, "R9 pulse ends", done, 0);
        repeat (4) @(negedge clk);
        check(done_cnt == 1, "R10 single done", done_cnt, 1);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !success && !shift_req, "R11 reset outputs", busy, 0);
        check(win_width == 0, "R11 reset width", win_width, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy, "R11 idle after reset", busy, 0);
        // sweep window widths and start phases
        for (int w = 1; w <= 20; w++) begin
            for (int p0 = 0; p0 < NPH; p0 += 4) begin
                run_case(p0, w, 0, 0, 0);
            end
        end
        // R2: flaky phase inside and at the edge of a window
        run_case(0, 12, 1, 15, 0);
        run_case(12, 14, 1, 10, 0);
        run_case(30, 18, 1, 27, 0);
        run_case(3, 9, 1, 11, 0);
        // R10: start pulse mid-run
        run_case(5, 16, 0, 0, 1);
        run_case(20, 19, 0, 0, 1);
        // R1: no good phase at all
        run_case(0, 0, 0, 0, 0);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule